// File: doc/BRIEF.md
# Integer Register Rename Map

This block sits between instruction decode and the issue logic of an out-of-order integer core. Every decoded instruction names two source registers and one destination register by their architectural index. For each instruction the block returns the physical register that holds the newest value of each source. It also returns a freshly allocated physical register for the destination and the physical register that the destination was mapped to before. The previous mapping travels with the instruction so that it can be released when the instruction retires.

Two maps are kept. The speculative map is read and written at rename time. The committed map records only retired instructions and is written through the commit port. When the core discovers a misprediction it raises the flush input. The speculative map is then overwritten with the committed map, and the pool of free physical registers is rebuilt from scratch: it holds every physical register that the committed map does not reference. With default parameters there are 32 architectural and 73 physical registers. Architectural register 31 is a hard zero, so 41 physical registers are available for values that are still in flight.

Top module: `rename_map_unit`

## Requirements
- R1: A rename that fires with a destination other than 31 returns, on ren_pdst, a physical register that is currently free. Free registers are handed out lowest index first, so the first allocations after reset are 32, 33, 34 and so on.
- R2: ren_psrc_a and ren_psrc_b return the current speculative mapping of their architectural sources. When a source equals the destination of the same request, it returns the older mapping. A rename that fires is visible to the sources of the next cycle's request.
- R3: ren_pold returns the speculative mapping that the destination held before this rename.
- R4: When no physical register is free and the destination is not 31, ren_ready is low. In that case the request changes neither map nor the free pool, and the next request sees an unchanged mapping.
- R5: Architectural index 31 always maps to physical 31, as a source and as a destination. A rename whose destination is 31 is accepted even when the free pool is empty, and it consumes no free register.
- R6: A commit (cmt_valid high, always accepted) with cmt_arch other than 31 writes cmt_pnew into the committed map and returns cmt_pold to the free pool. The returned register can be allocated from the next cycle on.
- R7: While flush is high, ren_ready is low. From the next cycle the speculative map equals the committed map, including a commit made in the flush cycle, and the free pool holds exactly the physical registers that map does not reference.
- R8: Synchronous active-high reset sets both maps to identity (architectural i to physical i) and fills the free pool with physical registers 32 to 72. ren_ready is high after reset.
- R9: A rename and a commit in the same cycle both take effect. A register returned by that commit is not handed out in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename request can be accepted this cycle |
| ren_src_a | input | 5 | First source architectural index |
| ren_src_b | input | 5 | Second source architectural index |
| ren_dst | input | 5 | Destination architectural index (31 = no write) |
| ren_psrc_a | output | 7 | Physical register for the first source |
| ren_psrc_b | output | 7 | Physical register for the second source |
| ren_pdst | output | 7 | Newly allocated physical destination |
| ren_pold | output | 7 | Previous physical mapping of the destination |
| cmt_valid | input | 1 | Retiring instruction present |
| cmt_arch | input | 5 | Architectural destination of the retiring instruction |
| cmt_pnew | input | 7 | Physical register that becomes architectural |
| cmt_pold | input | 7 | Physical register to release |
| flush | input | 1 | Misprediction recovery |

## Verification
Allocation at rename and release at commit both act on the free pool. The bench drives a rename and a commit in the same cycle, in a case where the committed release is a lower index than any free register. It then checks that the rename got the current lowest free register and that the released register is handed out only on the following request. A commit is also issued in the same cycle as a flush. The bench judges the result from the next request's sources and allocation, which must reflect the committed map that includes that commit, and from the rebuilt pool, whose lowest free index must be the register the commit displaced.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
    localparam int RNM_ARCH  = 32;
    localparam int RNM_EXTRA = 41;
    localparam int RNM_PHYS  = RNM_ARCH + RNM_EXTRA;
    localparam int AW        = $clog2(RNM_ARCH);
    localparam int PW        = $clog2(RNM_PHYS);
    localparam int ZERO_IDX  = RNM_ARCH - 1;

    typedef logic [AW-1:0] arch_t;
    typedef logic [PW-1:0] phys_t;
    typedef phys_t [RNM_ARCH-1:0] map_t;
    typedef logic [RNM_PHYS-1:0] pmask_t;

    localparam arch_t ZERO_ARCH = arch_t'(ZERO_IDX);
    localparam phys_t ZERO_PHYS = phys_t'(ZERO_IDX);

    typedef struct packed {
        logic  valid;
        arch_t arch;
        phys_t pnew;
        phys_t pold;
    } commit_t;

    typedef struct packed {
        phys_t psrc_a;
        phys_t psrc_b;
        phys_t pdst;
        phys_t pold;
    } ren_rsp_t;

    function automatic map_t identity_map();
        map_t m;
        for (int i = 0; i < RNM_ARCH; i++) m[i] = phys_t'(i);
        return m;
    endfunction

    // Bit p set when any map entry points at physical register p.
    function automatic pmask_t referenced(map_t m);
        pmask_t u;
        u = '0;
        for (int p = 0; p < RNM_PHYS; p++)
            for (int i = 0; i < RNM_ARCH; i++)
                if (m[i] == phys_t'(p)) u[p] = 1'b1;
        return u;
    endfunction
endpackage

// File: rtl/rnm_free_list.sv
module rnm_free_list
    import rnm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   alloc_en,
    input  logic   rel_en,
    input  phys_t  rel_idx,
    input  logic   rebuild,
    input  pmask_t keep_mask,
    output phys_t  alloc_idx,
    output logic   any_free,
    output pmask_t free_vec
);
    pmask_t free_q;
    pmask_t free_d;

    // Lowest-index free register wins.
    always_comb begin
        alloc_idx = '0;
        for (int p = RNM_PHYS - 1; p >= 0; p--)
            if (free_q[p]) alloc_idx = phys_t'(p);
    end

    assign any_free = |free_q;
    assign free_vec = free_q;

    always_comb begin
        if (rebuild) begin
            free_d = ~keep_mask;
        end else begin
            free_d = free_q;
            if (alloc_en) free_d[alloc_idx] = 1'b0;
            if (rel_en)   free_d[rel_idx]   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < RNM_PHYS; p++) free_q[p] <= (p >= RNM_ARCH);
        end else begin
            free_q <= free_d;
        end
    end
endmodule

// File: rtl/rnm_spec_map.sv
module rnm_spec_map
    import rnm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  arch_t rd_a,
    input  arch_t rd_b,
    input  arch_t rd_d,
    output phys_t q_a,
    output phys_t q_b,
    output phys_t q_d,
    input  logic  wr_en,
    input  arch_t wr_arch,
    input  phys_t wr_phys,
    input  logic  load,
    input  map_t  load_map,
    output map_t  map_q
);
    assign q_a = map_q[rd_a];
    assign q_b = map_q[rd_b];
    assign q_d = map_q[rd_d];

    always_ff @(posedge clk) begin
        if (rst)        map_q <= identity_map();
        else if (load)  map_q <= load_map;
        else if (wr_en) map_q[wr_arch] <= wr_phys;
    end
endmodule

// File: rtl/rnm_commit_map.sv
module rnm_commit_map
    import rnm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  commit_t cmt,
    output map_t    map_q,
    output map_t    map_next
);
    always_comb begin
        map_next = map_q;
        if (cmt.valid && cmt.arch != ZERO_ARCH) map_next[cmt.arch] = cmt.pnew;
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= identity_map();
        else     map_q <= map_next;
    end
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit
    import rnm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ren_valid,
    output logic                ren_ready,
    input  logic [AW-1:0]       ren_src_a,
    input  logic [AW-1:0]       ren_src_b,
    input  logic [AW-1:0]       ren_dst,
    output logic [PW-1:0]       ren_psrc_a,
    output logic [PW-1:0]       ren_psrc_b,
    output logic [PW-1:0]       ren_pdst,
    output logic [PW-1:0]       ren_pold,
    input  logic                cmt_valid,
    input  logic [AW-1:0]       cmt_arch,
    input  logic [PW-1:0]       cmt_pnew,
    input  logic [PW-1:0]       cmt_pold,
    input  logic                flush
);
    commit_t  cmt;
    ren_rsp_t rsp;
    map_t     spec_map_q;
    map_t     cmt_map_q;
    map_t     cmt_map_next;
    pmask_t   free_vec;
    phys_t    alloc_idx;
    phys_t    rd_a;
    phys_t    rd_b;
    phys_t    rd_d;
    logic     any_free;
    logic     needs_alloc;
    logic     alloc_fire;
    logic     rel_en;

    assign cmt = '{valid: cmt_valid, arch: cmt_arch, pnew: cmt_pnew, pold: cmt_pold};

    assign needs_alloc = (ren_dst != ZERO_ARCH);
    assign ren_ready   = !flush && (!needs_alloc || any_free);
    assign alloc_fire  = ren_valid && ren_ready && needs_alloc;
    assign rel_en      = cmt.valid && cmt.arch != ZERO_ARCH && cmt.pold != ZERO_PHYS;

    assign rsp = '{psrc_a: rd_a,
                   psrc_b: rd_b,
                   pdst:   needs_alloc ? alloc_idx : ZERO_PHYS,
                   pold:   rd_d};

    assign ren_psrc_a = rsp.psrc_a;
    assign ren_psrc_b = rsp.psrc_b;
    assign ren_pdst   = rsp.pdst;
    assign ren_pold   = rsp.pold;

    rnm_free_list u_free (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (alloc_fire),
        .rel_en    (rel_en),
        .rel_idx   (cmt.pold),
        .rebuild   (flush),
        .keep_mask (referenced(cmt_map_next)),
        .alloc_idx (alloc_idx),
        .any_free  (any_free),
        .free_vec  (free_vec)
    );

    rnm_spec_map u_spec (
        .clk      (clk),
        .rst      (rst),
        .rd_a     (ren_src_a),
        .rd_b     (ren_src_b),
        .rd_d     (ren_dst),
        .q_a      (rd_a),
        .q_b      (rd_b),
        .q_d      (rd_d),
        .wr_en    (alloc_fire),
        .wr_arch  (ren_dst),
        .wr_phys  (alloc_idx),
        .load     (flush),
        .load_map (cmt_map_next),
        .map_q    (spec_map_q)
    );

    rnm_commit_map u_cmt (
        .clk      (clk),
        .rst      (rst),
        .cmt      (cmt),
        .map_q    (cmt_map_q),
        .map_next (cmt_map_next)
    );
endmodule

// File: rtl/rename_map_unit_chk.sv
module rename_map_unit_chk
    import rnm_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   ren_valid,
    input logic   ren_ready,
    input arch_t  ren_src_a,
    input arch_t  ren_dst,
    input phys_t  ren_psrc_a,
    input phys_t  ren_pdst,
    input phys_t  ren_pold,
    input logic   cmt_valid,
    input arch_t  cmt_arch,
    input phys_t  cmt_pnew,
    input logic   flush,
    input logic   any_free,
    input pmask_t free_vec,
    input map_t   spec_map_q,
    input map_t   cmt_map_q
);
    logic fire_w;
    assign fire_w = ren_valid && ren_ready && ren_dst != ZERO_ARCH;

    p_fresh_dst_r1: assert property (@(posedge clk) disable iff (rst)
        fire_w |-> (free_vec[ren_pdst] && ren_pdst != ren_pold));

    p_newest_src_r2: assert property (@(posedge clk) disable iff (rst)
        fire_w |=> (ren_src_a != $past(ren_dst) || ren_psrc_a == $past(ren_pdst)));

    p_empty_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (!any_free && ren_dst != ZERO_ARCH) |-> !ren_ready);

    p_stall_keeps_map_r4: assert property (@(posedge clk) disable iff (rst)
        (!ren_ready && !flush) |=> $stable(spec_map_q));

    p_zero_src_r5: assert property (@(posedge clk) disable iff (rst)
        (ren_src_a == ZERO_ARCH) |-> (ren_psrc_a == ZERO_PHYS));

    p_commit_write_r6: assert property (@(posedge clk) disable iff (rst)
        (cmt_valid && cmt_arch != ZERO_ARCH) |=> (cmt_map_q[$past(cmt_arch)] == $past(cmt_pnew)));

    p_flush_restore_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (spec_map_q == cmt_map_q));

    p_flush_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        flush |-> !ren_ready);
endmodule

bind rename_map_unit rename_map_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ren_valid  (ren_valid),
    .ren_ready  (ren_ready),
    .ren_src_a  (ren_src_a),
    .ren_dst    (ren_dst),
    .ren_psrc_a (ren_psrc_a),
    .ren_pdst   (ren_pdst),
    .ren_pold   (ren_pold),
    .cmt_valid  (cmt_valid),
    .cmt_arch   (cmt_arch),
    .cmt_pnew   (cmt_pnew),
    .flush      (flush),
    .any_free   (any_free),
    .free_vec   (free_vec),
    .spec_map_q (spec_map_q),
    .cmt_map_q  (cmt_map_q)
);

// File: tb/rename_map_unit_tb.sv
module rename_map_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    typedef struct packed {
        logic [4:0] sa;
        logic [4:0] sb;
        logic [4:0] d;
        logic [6:0] psa;
        logic [6:0] psb;
        logic [6:0] pd;
        logic [6:0] po;
    } vec_t;

    // Renames from reset, no commits in between.
    localparam vec_t VECS [NVEC] = '{
        '{5'd1, 5'd2,  5'd1,  7'd1,  7'd2,  7'd32, 7'd1},
        '{5'd1, 5'd3,  5'd1,  7'd32, 7'd3,  7'd33, 7'd32},
        '{5'd1, 5'd31, 5'd5,  7'd33, 7'd31, 7'd34, 7'd5},
        '{5'd5, 5'd1,  5'd31, 7'd34, 7'd33, 7'd31, 7'd31},
        '{5'd5, 5'd5,  5'd2,  7'd34, 7'd34, 7'd35, 7'd2},
        '{5'd0, 5'd2,  5'd0,  7'd0,  7'd35, 7'd36, 7'd0}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       ren_valid;
    logic       ren_ready;
    logic [4:0] ren_src_a, ren_src_b, ren_dst;
    logic [6:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;
    logic       cmt_valid;
    logic [4:0] cmt_arch;
    logic [6:0] cmt_pnew, cmt_pold;
    logic       flush;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rename_map_unit u_dut (
        .clk(clk), .rst(rst),
        .ren_valid(ren_valid), .ren_ready(ren_ready),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_psrc_a(ren_psrc_a), .ren_psrc_b(ren_psrc_b),
        .ren_pdst(ren_pdst), .ren_pold(ren_pold),
        .cmt_valid(cmt_valid), .cmt_arch(cmt_arch),
        .cmt_pnew(cmt_pnew), .cmt_pold(cmt_pold),
        .flush(flush)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ren(input logic v, input int sa, input int sb, input int d);
        ren_valid = v;
        ren_src_a = 5'(sa);
        ren_src_b = 5'(sb);
        ren_dst   = 5'(d);
    endtask

    task automatic cmt(input logic v, input int a, input int pn, input int po);
        cmt_valid = v;
        cmt_arch  = 5'(a);
        cmt_pnew  = 7'(pn);
        cmt_pold  = 7'(po);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        finish_run();
    end

    initial begin
        int cnt;
        int last;
        rst = 1'b1;
        flush = 1'b0;
        ren(1'b0, 0, 0, 0);
        cmt(1'b0, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        ren(1'b0, 1, 31, 0);
        #1;
        check("R8 ready after reset", int'(ren_ready), 1);
        check("R8 identity map", int'(ren_psrc_a), 1);
        check("R1 first free is 32", int'(ren_pdst), 32);

        // Vector table: R1 R2 R3 R5
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            ren(1'b1, VECS[i].sa, VECS[i].sb, VECS[i].d);
            #1;
            check("R4 ready with free regs", int'(ren_ready), 1);
            check("R2 src a", int'(ren_psrc_a), int'(VECS[i].psa));
            check("R2 src b", int'(ren_psrc_b), int'(VECS[i].psb));
            check("R1 dst alloc", int'(ren_pdst), int'(VECS[i].pd));
            check("R3 old mapping", int'(ren_pold), int'(VECS[i].po));
        end

        // R7 flush with same-cycle commit of arch1 -> 32
        @(negedge clk);
        ren(1'b1, 1, 5, 3);
        cmt(1'b1, 1, 32, 1);
        flush = 1'b1;
        #1;
        check("R7 ready low in flush", int'(ren_ready), 0);
        @(negedge clk);
        flush = 1'b0;
        cmt(1'b0, 0, 0, 0);
        #1;
        check("R7 restored committed src", int'(ren_psrc_a), 32);
        check("R7 discarded speculative src", int'(ren_psrc_b), 5);
        check("R7 rebuilt pool lowest", int'(ren_pdst), 1);
        check("R7 restored old mapping", int'(ren_pold), 3);

        // R9 rename and commit together
        @(negedge clk);
        ren(1'b1, 3, 0, 4);
        cmt(1'b1, 3, 1, 3);
        #1;
        check("R9 alloc ignores same-cycle release", int'(ren_pdst), 33);
        check("R2 previous rename visible", int'(ren_psrc_a), 1);
        @(negedge clk);
        cmt(1'b0, 0, 0, 0);
        ren(1'b1, 4, 4, 6);
        #1;
        check("R6 released reg reused", int'(ren_pdst), 3);
        check("R2 src after rename", int'(ren_psrc_a), 33);

        // R4 exhaust the pool
        cnt = 0;
        last = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            ren(1'b1, 7, 0, 7);
            #1;
            if (!ren_ready) break;
            cnt++;
            last = int'(ren_pdst);
        end
        check("R4 allocations until empty", cnt, 39);
        check("R1 last allocation ascending", last, 72);
        check("R4 ready low when empty", int'(ren_ready), 0);
        ren(1'b1, 31, 31, 31);
        #1;
        check("R5 zero dst accepted when empty", int'(ren_ready), 1);
        check("R5 zero dst phys", int'(ren_pdst), 31);
        check("R5 zero src phys", int'(ren_psrc_a), 31);
        @(negedge clk);
        ren(1'b1, 7, 0, 7);
        cmt(1'b1, 7, 72, 40);
        #1;
        check("R4 stall keeps map", int'(ren_psrc_a), 72);
        check("R9 release not usable same cycle", int'(ren_ready), 0);
        @(negedge clk);
        cmt(1'b0, 0, 0, 0);
        #1;
        check("R6 ready after release", int'(ren_ready), 1);
        check("R6 released reg allocated", int'(ren_pdst), 40);
        check("R3 old mapping after stall", int'(ren_pold), 72);

        // R8 reset again
        @(negedge clk);
        rst = 1'b1;
        ren(1'b0, 7, 0, 7);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8 map identity after reset", int'(ren_psrc_a), 7);
        check("R8 pool refilled", int'(ren_pdst), 32);
        check("R8 ready after reset", int'(ren_ready), 1);

        finish_run();
    end
endmodule